// File: doc/BRIEF.md
# Serial EEPROM and PHY Management Access Sequencer

This block lets a host move one 16-bit word to or from either an external Microwire-style serial EEPROM or a register in an Ethernet PHY reached over the MDIO management bus. The host loads an address register and a write-data register, then writes an 8-bit command register. One bit picks the target, one starts a read and one starts a write. A read result appears in a separate read-data register. The start bits stay set while the serial transfer runs and drop by themselves when it ends, so polling them tells the host when the word is ready.

The command register also shows two strap inputs: one says that no EEPROM is fitted, the other gives the EEPROM address width. It also holds a write-enable guard for EEPROM programming and a reload request. The reload request is a plain level that other logic can watch. Only the host clears it. Both serial buses share a single bit engine, and its clock is the system clock divided by a parameter.

Top module: `eeMdioSeq`

## Requirements
- R1: After reset, command bits 5 to 1 read 0, EEPROM chip select is low, the MDIO output enable is low, and the serial bus is driven only while a start bit (bit 2 or bit 1) reads 1.
- R2: Command bit 7 reads the `eeAbsent` input and bit 6 reads the `eeWide` input (0 means a 64-word part with 6 address bits, 1 means 8 address bits). Host writes to these two bits have no effect.
- R3: Writing 1 to bit 2 starts a read of the selected target. Bit 2 drops to 0 when the transfer finishes. `rdData` takes the received word in that same cycle and does not change at any other time.
- R4: Writing 1 to bit 1 starts a write to the selected target, and bit 1 drops to 0 when the transfer finishes.
- R5: Bit 3 selects the target: 0 selects the EEPROM pins and 1 selects the MDIO pins. The unselected bus stays idle, and chip select and MDIO output enable are never high together.
- R6: An EEPROM read holds chip select high for one frame made of bits 1,1,0, then the address MSB first (6 or 8 bits, per bit 6), then 16 clocks. During those 16 clocks the data bit is sampled on each rising serial clock, MSB first.
- R7: An EEPROM write sends two frames with chip select low between them. The first is the enable command: bits 1,0,0,1,1 followed by zeros up to the address width. The second is bits 1,0,1, then the address, then the 16 data bits, all MSB first.
- R8: If the host requests an EEPROM write while write-enable bit 4 is 0, the request finishes at once. Bit 1 reads 0 from the next cycle on, chip select is never raised, and the EEPROM contents stay the same.
- R9: A PHY frame is 64 clocks long, bits sent MSB first. It carries 32 ones, then 0,1, then the opcode (1,0 for a read, 0,1 for a write), then the `phyId` input (5 bits), then address register bits 4:0. The turnaround follows: it is released on a read and driven 1,0 on a write. The last part is 16 data bits, which the PHY drives on a read and which come from the write-data register on a write.
- R10: A command-register write that arrives while bit 2 or bit 1 is set is ignored in full, including bits 5, 4 and 3.
- R11: Bit 5 drives `reloadReq` and keeps its value until the host writes the command register again.
- R12: Each high phase of the serial clock lasts exactly CLK_DIV system cycles.
- R13: If bits 2 and 1 are both written as 1, only the read starts and bit 1 stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWe | input | 1 | Command register write strobe |
| cmdWData | input | 8 | Command register write value |
| cmdReg | output | 8 | Command register read value |
| addrWe | input | 1 | Address register write strobe |
| addrWData | input | 8 | Word address (EEPROM) or register number in bits 4:0 (PHY) |
| dataWe | input | 1 | Write-data register write strobe |
| dataWData | input | 16 | Word to be written |
| rdData | output | 16 | Word returned by the last read |
| phyId | input | 5 | PHY address placed in MDIO frames |
| eeAbsent | input | 1 | Strap: no EEPROM detected |
| eeWide | input | 1 | Strap: EEPROM uses 8 address bits |
| reloadReq | output | 1 | Reload request level (command bit 5) |
| eeCs | output | 1 | EEPROM chip select |
| eeSk | output | 1 | EEPROM serial clock |
| eeDi | output | 1 | Serial data to EEPROM |
| eeDo | input | 1 | Serial data from EEPROM |
| mdc | output | 1 | MDIO management clock |
| mdio | output | 1 | MDIO output value |
| mdioOe | output | 1 | MDIO output enable |
| mdioIn | input | 1 | MDIO input value |

## Verification
The bench builds the block with CLK_DIV set to 2. This keeps a 64-clock PHY frame under 300 system cycles, so dozens of full EEPROM and PHY transfers fit in one run. A divider above 1 still leaves room for the divider counter to show a high phase that is too short or too long. Behavioural models of the EEPROM and the PHY decode every frame bit by bit, and the bench drives `eeWide` both ways so that both address widths are exercised on real frames.

// File: rtl/eeMdioSeqPkg.sv
package eeMdioSeqPkg;
  localparam int WORD_W    = 16;
  localparam int ADDR_W    = 8;
  localparam int NARROW_W  = 6;
  localparam int FRAME_W   = 64;
  localparam int LEN_W     = $clog2(FRAME_W + 1);
  localparam int PHY_W     = 5;
  localparam int TA_BITS   = 2;

  typedef enum logic [2:0] {
    FR_NONE, FR_EE_RD, FR_EE_EWEN, FR_EE_WR, FR_PHY_RD, FR_PHY_WR
  } frameKind_t;

  typedef struct packed {
    logic       load;
    frameKind_t kind;
  } seqStrobe_t;
endpackage

// File: rtl/eeMdioSeqDatapath.sv
module eeMdioSeqDatapath
  import eeMdioSeqPkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          strobe,
  input  logic                eeWide,
  input  logic [PHY_W-1:0]    phyId,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [WORD_W-1:0]   wrWord,
  input  logic                eeDo,
  input  logic                mdioIn,
  output logic                frameDone,
  output logic [WORD_W-1:0]   rxWord,
  output logic                eeCs,
  output logic                eeSk,
  output logic                eeDi,
  output logic                mdc,
  output logic                mdio,
  output logic                mdioOe
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
  localparam logic [LEN_W-1:0] RX_LEN   = LEN_W'(WORD_W);
  localparam logic [LEN_W-1:0] PHY_HOLD = LEN_W'(WORD_W + TA_BITS);

  logic [FRAME_W-1:0] frameBits, txSh;
  logic [LEN_W-1:0]   frameLen, bitsLeft;
  logic [DIV_W-1:0]   divCnt;
  logic [WORD_W-1:0]  rxSh;
  frameKind_t         kindQ;
  logic               active, phase, doneQ, tick, isEe, isPhy, rxOn, rxBit;

  always_comb begin
    frameBits = '0;
    frameLen  = '0;
    unique case (strobe.kind)
      FR_EE_RD: begin
        if (eeWide) begin
          frameBits = {3'b110, addr, {(FRAME_W-3-ADDR_W){1'b0}}};
          frameLen  = LEN_W'(3 + ADDR_W + WORD_W);
        end else begin
          frameBits = {3'b110, addr[NARROW_W-1:0], {(FRAME_W-3-NARROW_W){1'b0}}};
          frameLen  = LEN_W'(3 + NARROW_W + WORD_W);
        end
      end
      FR_EE_EWEN: begin
        if (eeWide) begin
          frameBits = {5'b10011, {(FRAME_W-5){1'b0}}};
          frameLen  = LEN_W'(3 + ADDR_W);
        end else begin
          frameBits = {5'b10011, {(FRAME_W-5){1'b0}}};
          frameLen  = LEN_W'(3 + NARROW_W);
        end
      end
      FR_EE_WR: begin
        if (eeWide) begin
          frameBits = {3'b101, addr, wrWord, {(FRAME_W-3-ADDR_W-WORD_W){1'b0}}};
          frameLen  = LEN_W'(3 + ADDR_W + WORD_W);
        end else begin
          frameBits = {3'b101, addr[NARROW_W-1:0], wrWord,
                       {(FRAME_W-3-NARROW_W-WORD_W){1'b0}}};
          frameLen  = LEN_W'(3 + NARROW_W + WORD_W);
        end
      end
      FR_PHY_RD: begin
        frameBits = {32'hFFFF_FFFF, 4'b0110, phyId, addr[4:0], 2'b00, {WORD_W{1'b0}}};
        frameLen  = LEN_W'(FRAME_W);
      end
      FR_PHY_WR: begin
        frameBits = {32'hFFFF_FFFF, 4'b0101, phyId, addr[4:0], 2'b10, wrWord};
        frameLen  = LEN_W'(FRAME_W);
      end
      default: ;
    endcase
  end

  assign isEe  = (kindQ == FR_EE_RD) || (kindQ == FR_EE_EWEN) || (kindQ == FR_EE_WR);
  assign isPhy = (kindQ == FR_PHY_RD) || (kindQ == FR_PHY_WR);
  assign tick  = active && (divCnt == DIV_LAST);
  assign rxOn  = ((kindQ == FR_EE_RD) || (kindQ == FR_PHY_RD)) && (bitsLeft <= RX_LEN);
  assign rxBit = isPhy ? mdioIn : eeDo;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= 1'b0;
      phase    <= 1'b0;
      divCnt   <= '0;
      bitsLeft <= '0;
      txSh     <= '0;
      rxSh     <= '0;
      kindQ    <= FR_NONE;
      doneQ    <= 1'b0;
    end else if (strobe.load) begin
      active   <= 1'b1;
      phase    <= 1'b0;
      divCnt   <= '0;
      bitsLeft <= frameLen;
      txSh     <= frameBits;
      rxSh     <= '0;
      kindQ    <= strobe.kind;
      doneQ    <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (active) begin
        divCnt <= tick ? '0 : divCnt + 1'b1;
      end
      if (tick) begin
        if (!phase) begin
          phase <= 1'b1;
          if (rxOn) rxSh <= {rxSh[WORD_W-2:0], rxBit};
        end else begin
          phase    <= 1'b0;
          txSh     <= {txSh[FRAME_W-2:0], 1'b0};
          bitsLeft <= bitsLeft - 1'b1;
          if (bitsLeft == LEN_W'(1)) begin
            active <= 1'b0;
            doneQ  <= 1'b1;
          end
        end
      end
    end
  end

  assign frameDone = doneQ;
  assign rxWord    = rxSh;
  assign eeCs      = active && isEe;
  assign eeSk      = phase && isEe;
  assign eeDi      = active && isEe && txSh[FRAME_W-1];
  assign mdc       = phase && isPhy;
  assign mdio      = active && isPhy && txSh[FRAME_W-1];
  assign mdioOe    = active && isPhy && ((kindQ == FR_PHY_WR) || (bitsLeft > PHY_HOLD));
endmodule

// File: rtl/eeMdioSeqCtrl.sv
module eeMdioSeqCtrl
  import eeMdioSeqPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWe,
  input  logic [7:0]        cmdWData,
  input  logic              eeAbsent,
  input  logic              eeWide,
  input  logic              frameDone,
  input  logic [WORD_W-1:0] rxWord,
  output logic [7:0]        cmdReg,
  output seqStrobe_t        strobe,
  output logic [WORD_W-1:0] rdData
);
  typedef enum logic [1:0] {ST_IDLE, ST_EWEN, ST_GAP, ST_XFER} ctrlState_t;

  ctrlState_t state;
  logic reloadB, wenB, selB, rdB, wrB;
  logic newSel, newWen;

  assign newSel = cmdWData[3];
  assign newWen = cmdWData[4];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      reloadB <= 1'b0;
      wenB    <= 1'b0;
      selB    <= 1'b0;
      rdB     <= 1'b0;
      wrB     <= 1'b0;
      rdData  <= '0;
      strobe  <= '{load: 1'b0, kind: FR_NONE};
    end else begin
      strobe.load <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (cmdWe) begin
            reloadB <= cmdWData[5];
            wenB    <= newWen;
            selB    <= newSel;
            if (cmdWData[2]) begin
              rdB    <= 1'b1;
              strobe <= '{load: 1'b1, kind: newSel ? FR_PHY_RD : FR_EE_RD};
              state  <= ST_XFER;
            end else if (cmdWData[1] && (newSel || newWen)) begin
              wrB    <= 1'b1;
              strobe <= '{load: 1'b1, kind: newSel ? FR_PHY_WR : FR_EE_EWEN};
              state  <= newSel ? ST_XFER : ST_EWEN;
            end
          end
        end
        ST_EWEN: if (frameDone) state <= ST_GAP;
        ST_GAP: begin
          strobe <= '{load: 1'b1, kind: FR_EE_WR};
          state  <= ST_XFER;
        end
        ST_XFER: begin
          if (frameDone) begin
            if (rdB) rdData <= rxWord;
            rdB   <= 1'b0;
            wrB   <= 1'b0;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cmdReg = {eeAbsent, eeWide, reloadB, wenB, selB, rdB, wrB, 1'b0};
endmodule

// File: rtl/eeMdioSeq.sv
module eeMdioSeq
  import eeMdioSeqPkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdWe,
  input  logic [7:0]  cmdWData,
  output logic [7:0]  cmdReg,
  input  logic        addrWe,
  input  logic [7:0]  addrWData,
  input  logic        dataWe,
  input  logic [15:0] dataWData,
  output logic [15:0] rdData,
  input  logic [4:0]  phyId,
  input  logic        eeAbsent,
  input  logic        eeWide,
  output logic        reloadReq,
  output logic        eeCs,
  output logic        eeSk,
  output logic        eeDi,
  input  logic        eeDo,
  output logic        mdc,
  output logic        mdio,
  output logic        mdioOe,
  input  logic        mdioIn
);
  seqStrobe_t        strobe;
  logic              frameDone;
  logic [WORD_W-1:0] rxWord, wrWord;
  logic [ADDR_W-1:0] addrQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wrWord <= '0;
    end else begin
      if (addrWe) addrQ  <= addrWData;
      if (dataWe) wrWord <= dataWData;
    end
  end

  eeMdioSeqCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdWe(cmdWe), .cmdWData(cmdWData),
    .eeAbsent(eeAbsent), .eeWide(eeWide), .frameDone(frameDone),
    .rxWord(rxWord), .cmdReg(cmdReg), .strobe(strobe), .rdData(rdData)
  );

  eeMdioSeqDatapath #(.CLK_DIV(CLK_DIV)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .eeWide(eeWide), .phyId(phyId),
    .addr(addrQ), .wrWord(wrWord), .eeDo(eeDo), .mdioIn(mdioIn),
    .frameDone(frameDone), .rxWord(rxWord), .eeCs(eeCs), .eeSk(eeSk),
    .eeDi(eeDi), .mdc(mdc), .mdio(mdio), .mdioOe(mdioOe)
  );

  assign reloadReq = cmdReg[5];
endmodule

// File: rtl/eeMdioSeqChk.sv
module eeMdioSeqChk (
  input logic        clk,
  input logic        rstN,
  input logic        cmdWe,
  input logic [7:0]  cmdReg,
  input logic [15:0] rdData,
  input logic        reloadReq,
  input logic        eeCs,
  input logic        mdioOe
);
  // R1
  bus_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdReg[2] || cmdReg[1]) |-> (!eeCs && !mdioOe));

  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(cmdReg[2]) |-> $stable(rdData));

  // R5
  one_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(eeCs && mdioOe));

  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((cmdReg[2] || cmdReg[1]) && cmdWe) |=> $stable(cmdReg[5:3]));

  // R11
  reload_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmdWe |=> $stable(reloadReq));

  // R13
  rd_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdReg[2] && cmdReg[1]));
endmodule

bind eeMdioSeq eeMdioSeqChk u_chk (
  .clk(clk), .rstN(rstN), .cmdWe(cmdWe), .cmdReg(cmdReg), .rdData(rdData),
  .reloadReq(reloadReq), .eeCs(eeCs), .mdioOe(mdioOe)
);

// File: tb/eeMdioSeq_bench.sv
module eeMdioSeq_bench;
  localparam int CLK_DIV = 2;
  localparam logic [4:0] PHY_ID = 5'h0B;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdWe = 1'b0, addrWe = 1'b0, dataWe = 1'b0;
  logic [7:0] cmdWData = '0, addrWData = '0;
  logic [15:0] dataWData = '0;
  logic eeAbsent = 1'b0, eeWide = 1'b0;
  logic eeDo = 1'b0, mdioIn = 1'b1;
  logic [7:0] cmdReg;
  logic [15:0] rdData;
  logic reloadReq, eeCs, eeSk, eeDi, mdc, mdio, mdioOe;

  int nChecks = 0, nFails = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  eeMdioSeq #(.CLK_DIV(CLK_DIV)) u_eeMdioSeq (
    .clk(clk), .rstN(rstN), .cmdWe(cmdWe), .cmdWData(cmdWData), .cmdReg(cmdReg),
    .addrWe(addrWe), .addrWData(addrWData), .dataWe(dataWe), .dataWData(dataWData),
    .rdData(rdData), .phyId(PHY_ID), .eeAbsent(eeAbsent), .eeWide(eeWide),
    .reloadReq(reloadReq), .eeCs(eeCs), .eeSk(eeSk), .eeDi(eeDi), .eeDo(eeDo),
    .mdc(mdc), .mdio(mdio), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  // ---------------- EEPROM model ----------------
  logic [15:0] eeMem [256];
  logic [39:0] eeSh = '0;
  int eeCnt = 0;
  logic [1:0] eeOp = 2'b00;
  logic [7:0] eeAddr = '0;
  logic eeWen = 1'b0;

  function automatic int addrBits();
    return eeWide ? 8 : 6;
  endfunction

  always @(posedge eeSk or negedge eeCs) begin
    if (!eeCs) begin
      eeCnt = 0;
      eeOp  = 2'b00;
    end else begin
      eeSh  = {eeSh[38:0], eeDi};
      eeCnt = eeCnt + 1;
      if (eeCnt == 3 + addrBits()) begin
        eeOp   = eeSh[addrBits()+1 -: 2];
        eeAddr = eeWide ? eeSh[7:0] : {2'b00, eeSh[5:0]};
        if (eeOp == 2'b00 && eeSh[addrBits()-1 -: 2] == 2'b11) eeWen = 1'b1;
      end
      if (eeCnt == 3 + addrBits() + 16 && eeOp == 2'b01 && eeWen)
        eeMem[eeAddr] = eeSh[15:0];
    end
  end

  always @(negedge eeSk) begin
    if (eeCs && eeOp == 2'b10 && eeCnt >= 3 + addrBits() && eeCnt < 3 + addrBits() + 16)
      eeDo = eeMem[eeAddr][15 - (eeCnt - 3 - addrBits())];
  end

  // ---------------- PHY model ----------------
  logic [15:0] phyMem [32];
  logic [63:0] phSh = '0;
  int phCnt = 0;
  logic [1:0] phOp = 2'b00;
  logic [4:0] phReg = '0;
  int phyBad = 0;

  always @(posedge mdc) begin
    phSh  = {phSh[62:0], mdioOe ? mdio : 1'b1};
    phCnt = phCnt + 1;
    if (phCnt == 46) begin
      if (phSh[45:14] != 32'hFFFF_FFFF || phSh[13:12] != 2'b01 || phSh[9:5] != PHY_ID)
        phyBad = phyBad + 1;
      phOp  = phSh[11:10];
      phReg = phSh[4:0];
    end
    if (phCnt == 48 && phOp == 2'b01 && phSh[1:0] != 2'b10) phyBad = phyBad + 1;
    if (phCnt == 64) begin
      if (phOp == 2'b01) phyMem[phReg] = phSh[15:0];
      phCnt = 0;
      phOp  = 2'b00;
    end
  end

  always @(negedge mdc) begin
    if (phOp == 2'b10 && phCnt >= 48 && phCnt < 64)
      mdioIn = phyMem[phReg][63 - phCnt];
  end

  // ---------------- bus monitors ----------------
  int highRun = 0, badHigh = 0, highSeen = 0;
  int eeCsSeen = 0;
  always @(negedge clk) begin
    cycles = cycles + 1;
    if (eeCs) eeCsSeen = eeCsSeen + 1;
    if (eeSk || mdc) highRun = highRun + 1;
    else if (highRun != 0) begin
      highSeen = highSeen + 1;
      if (highRun != CLK_DIV) badHigh = badHigh + 1;
      highRun = 0;
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeCmd(input logic [7:0] v);
    @(negedge clk); cmdWData = v; cmdWe = 1'b1;
    @(negedge clk); cmdWe = 1'b0;
  endtask

  task automatic setOperands(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); addrWData = a; dataWData = d; addrWe = 1'b1; dataWe = 1'b1;
    @(negedge clk); addrWe = 1'b0; dataWe = 1'b0;
  endtask

  task automatic waitDone(input string req);
    int n = 0;
    while ((cmdReg[2] || cmdReg[1]) && n < 3000) begin
      @(negedge clk); n++;
    end
    check(n < 3000, req, n, 0);
  endtask

  function automatic logic [7:0] maskAddr(input logic [7:0] a, input logic wide);
    return wide ? a : {2'b00, a[5:0]};
  endfunction

  initial begin
    for (int i = 0; i < 256; i++) eeMem[i] = 16'(i * 16'h0101 ^ 16'h5A3C);
    for (int i = 0; i < 32; i++) phyMem[i] = 16'(i * 16'h1111 + 16'h0F0F);
  end

  // watchdog
  initial begin
    #(5.0 * 150000);
    nFails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [7:0] a;
    logic [15:0] d, prev;
    void'($urandom(32'd1977));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(cmdReg == 8'h00, "R1 reset cmd", cmdReg, 8'h00);
    check(!eeCs && !mdioOe, "R1 reset bus", {eeCs, mdioOe}, 0);

    // R2 straps and read-only bits
    eeAbsent = 1'b1; eeWide = 1'b1;
    writeCmd(8'h00);
    check(cmdReg == 8'hC0, "R2 straps", cmdReg, 8'hC0);
    eeAbsent = 1'b0; eeWide = 1'b0;
    writeCmd(8'hC0);
    check(cmdReg == 8'h00, "R2 write ignored", cmdReg, 8'h00);

    // R11 reload level holds until host clears
    writeCmd(8'h20);
    repeat (10) @(negedge clk);
    check(reloadReq == 1'b1 && cmdReg[5], "R11 reload held", reloadReq, 1);
    writeCmd(8'h00);
    check(reloadReq == 1'b0, "R11 reload cleared", reloadReq, 0);

    // R6 R7 R4 R3 random EEPROM writes and reads, both widths
    for (int it = 0; it < 8; it++) begin
      eeWide = it[0];
      a = 8'($urandom);
      d = 16'($urandom);
      setOperands(a, d);
      writeCmd(8'h12);
      waitDone("R4 write completes");
      check(cmdReg[1] == 1'b0, "R4 write bit self-clears", cmdReg[1], 0);
      check(eeMem[maskAddr(a, eeWide)] == d, "R7 EEPROM word written",
            eeMem[maskAddr(a, eeWide)], d);
      prev = rdData;
      writeCmd(8'h04);
      check(cmdReg[2] == 1'b1 && rdData == prev, "R3 rdData held while busy", rdData, prev);
      waitDone("R3 read completes");
      check(rdData == d, "R6 EEPROM read word", rdData, d);
    end

    // R6 directed boundary addresses: untouched locations
    eeWide = 1'b1;
    setOperands(8'hFF, 16'h0);
    d = eeMem[8'hFF];
    writeCmd(8'h04);
    waitDone("R6 read top");
    check(rdData == d, "R6 top address wide", rdData, d);
    eeWide = 1'b0;
    setOperands(8'hC0, 16'h0);
    d = eeMem[8'h00];
    writeCmd(8'h04);
    waitDone("R6 read narrow");
    check(rdData == d, "R6 narrow ignores upper address bits", rdData, d);

    // R8 EEPROM write with enable clear
    setOperands(8'h05, 16'hDEAD);
    d = eeMem[8'h05];
    eeCsSeen = 0;
    writeCmd(8'h02);
    check(cmdReg[1] == 1'b0, "R8 bit reads 0", cmdReg[1], 0);
    repeat (60) @(negedge clk);
    check(eeCsSeen == 0, "R8 no bus activity", eeCsSeen, 0);
    check(eeMem[8'h05] == d, "R8 contents kept", eeMem[8'h05], d);

    // R9 R5 PHY writes and reads
    for (int it = 0; it < 5; it++) begin
      a = 8'($urandom);
      d = 16'($urandom);
      setOperands(a, d);
      eeCsSeen = 0;
      writeCmd(8'h0A);
      waitDone("R4 PHY write completes");
      check(phyMem[a[4:0]] == d, "R9 PHY register written", phyMem[a[4:0]], d);
      writeCmd(8'h0C);
      waitDone("R3 PHY read completes");
      check(rdData == d, "R9 PHY read word", rdData, d);
      check(eeCsSeen == 0, "R5 EEPROM idle during PHY", eeCsSeen, 0);
    end
    check(phyBad == 0, "R9 PHY frame fields", phyBad, 0);

    // R10 write while busy is ignored
    setOperands(8'h11, 16'h0);
    d = eeMem[8'h11];
    writeCmd(8'h04);
    writeCmd(8'h38);
    waitDone("R10 read completes");
    check(cmdReg[5:3] == 3'b000, "R10 busy write ignored", cmdReg[5:3], 0);
    check(rdData == d, "R10 read unaffected", rdData, d);

    // R13 read wins
    setOperands(8'h22, 16'hBEEF);
    d = eeMem[8'h22];
    writeCmd(8'h16);
    check(cmdReg[2:1] == 2'b10, "R13 only read started", cmdReg[2:1], 2'b10);
    waitDone("R13 completes");
    check(rdData == d && eeMem[8'h22] == d, "R13 no write performed", rdData, d);

    // R12 serial clock high phase
    check(highSeen > 0 && badHigh == 0, "R12 high phase length", badHigh, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule